// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block sits between a bank of pads and the peripherals that share them. Each line of the port belongs either to software-driven general-purpose I/O or to one peripheral signal. The owner decides what drives the pad's output value and output enable. Lines marked as dedicated GPIO in a build parameter are never handed to a peripheral. While GPIO owns a line, the peripheral sees a constant 0 on that line's input.

Software reaches the block through a simple synchronous register bus. Five per-line state vectors each have a write-one-to-set register, a write-one-to-clear register and a read-only status register: owner, output enable, output data, glitch-filter enable and interrupt mask. The state vectors are ownership, direction, output data, filtering and interrupt mask.

Every pad input goes through a two-flop synchronizer and an optional glitch filter. The filtered level can be read back. Any change of that level sets a sticky change bit, whatever the line's owner or direction. The change register clears when it is read. A single interrupt output is raised while any change bit is set and unmasked.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset every existing line reads 1 in the owner status, so GPIO owns every multiplexed line. Output enable, data, filter enable, mask and change status all read 0, and `irq` is low.
- R2: Word addresses: field f has its set register at 3f, its clear register at 3f+1 and its status register at 3f+2. The fields are f=0 owner (1 = GPIO), f=1 output enable, f=2 output data, f=3 filter enable and f=4 interrupt mask. Writing 1s to a set register sets the matching status bits, writing 1s to a clear register clears them, and 0 bits leave the state unchanged.
- R3: For dedicated lines (MUX_MASK bit 0), writes to the owner set and clear registers have no effect, and their owner status bits always read 1.
- R4: `per_in` is 0 on every line that GPIO owns. On a line the peripheral owns, it equals the synchronized, filtered pad level.
- R5: On a GPIO-owned line, `pad_out` and `pad_oe` follow the data and output-enable status bits. On a peripheral-owned line they follow `per_out` and `per_oe`.
- R6: The pin-level register at address 15 returns the synchronized, filtered pad level on every line, whoever owns the line. An unfiltered pad change is readable from the third clock after it.
- R7: With filtering enabled on a line, a pad pulse lasting one clock changes neither the pin level nor the change status. A pulse of three clocks is accepted. With filtering disabled, a one-clock pulse is seen.
- R8: Any change of a line's filtered level sets that line's bit in the change status register at address 16, whether the line is an input or an output and whoever owns it.
- R9: Reading address 16 returns the change status and then clears it. A change detected in the same cycle as that read stays set.
- R10: `irq` is high exactly when some line has both its change bit and its mask bit set.
- R11: Bits of lines at or above N_LINES ignore writes and read 0. Unmapped addresses read 0.
- R12: Read data is presented on `reg_rdata` in the cycle after the read strobe, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pad_in | input | N_LINES | Level present on each pad |
| pad_out | output | N_LINES | Value driven to each pad |
| pad_oe | output | N_LINES | Output enable for each pad |
| per_out | input | N_LINES | Peripheral output value per line |
| per_oe | input | N_LINES | Peripheral output enable per line |
| per_in | output | N_LINES | Input delivered to the peripheral per line |
| irq | output | 1 | Combined change interrupt |

## Verification
The bench builds the port with N_LINES=12 and MUX_MASK=12'hF3C, so lines 0, 1, 6 and 7 are dedicated. This narrow width lets every line be walked through every set, clear and change test. It also places the upper twenty bus bits outside the port, which exercises the ignored-bit rule. The pad-drive and peripheral-input checks sweep several data patterns against both ownership states. The timing of the read-clear collision is reached by placing a pad change exactly three clocks before the read strobe.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 5;
    localparam int N_FIELDS = 5;

    typedef enum logic [2:0] {
        FLD_OWN = 3'd0,
        FLD_OE  = 3'd1,
        FLD_DAT = 3'd2,
        FLD_FLT = 3'd3,
        FLD_MSK = 3'd4
    } field_e;

    localparam logic [ADDR_W-1:0] ADDR_PIN = 5'd15;
    localparam logic [ADDR_W-1:0] ADDR_CHG = 5'd16;

    typedef struct packed {
        logic       is_set;
        logic       is_clr;
        logic       is_stat;
        logic [2:0] fld;
    } addr_dec_t;

    function automatic addr_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        addr_dec_t d;
        int unsigned ai;
        ai = int'(a);
        d = '0;
        if (ai < 3 * N_FIELDS) begin
            d.fld     = 3'(ai / 3);
            d.is_set  = (ai % 3) == 0;
            d.is_clr  = (ai % 3) == 1;
            d.is_stat = (ai % 3) == 2;
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank #(
    parameter int               N_LINES   = 32,
    parameter logic [N_LINES-1:0] FIX_MASK  = '0,
    parameter logic [N_LINES-1:0] RST_VAL   = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_en,
    input  logic               clr_en,
    input  logic [N_LINES-1:0] wbits,
    output logic [N_LINES-1:0] q
);
    logic [N_LINES-1:0] q_r;
    logic [N_LINES-1:0] q_nxt;

    always_comb begin
        q_nxt = q_r;
        if (set_en) q_nxt = q_nxt | wbits;
        if (clr_en) q_nxt = q_nxt & ~wbits;
        q_nxt = (q_nxt & ~FIX_MASK) | (RST_VAL & FIX_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) q_r <= RST_VAL;
        else     q_r <= q_nxt;
    end

    assign q = q_r;
endmodule

// File: rtl/gpio_in_path.sv
module gpio_in_path #(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] pad_in,
    input  logic [N_LINES-1:0] flt_en,
    output logic [N_LINES-1:0] lvl,
    output logic [N_LINES-1:0] chg_pulse
);
    logic [N_LINES-1:0] meta_q, sync_q, prev_q, filt_q, filt_d;
    logic [N_LINES-1:0] filt_nxt;

    // a filtered line moves only when two successive samples agree
    always_comb begin
        for (int i = 0; i < N_LINES; i++) begin
            if (!flt_en[i])                 filt_nxt[i] = sync_q[i];
            else if (sync_q[i] == prev_q[i]) filt_nxt[i] = sync_q[i];
            else                            filt_nxt[i] = filt_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
            filt_q <= '0;
            filt_d <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
            filt_q <= filt_nxt;
            filt_d <= filt_q;
        end
    end

    assign lvl       = filt_q;
    assign chg_pulse = filt_q ^ filt_d;
endmodule

// File: rtl/gpio_chg_status.sv
module gpio_chg_status #(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] chg_pulse,
    input  logic               rd_clr,
    output logic [N_LINES-1:0] chg
);
    logic [N_LINES-1:0] chg_r;

    always_ff @(posedge clk) begin
        if (rst) chg_r <= '0;
        else     chg_r <= (rd_clr ? '0 : chg_r) | chg_pulse;
    end

    assign chg = chg_r;
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpio_mux_pkg::*;
#(
    parameter int                 N_LINES  = 32,
    parameter logic [N_LINES-1:0] MUX_MASK = '1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [4:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [N_LINES-1:0] pad_in,
    output logic [N_LINES-1:0] pad_out,
    output logic [N_LINES-1:0] pad_oe,
    input  logic [N_LINES-1:0] per_out,
    input  logic [N_LINES-1:0] per_oe,
    output logic [N_LINES-1:0] per_in,
    output logic               irq
);
    localparam logic [N_LINES-1:0] DEDICATED = ~MUX_MASK;

    addr_dec_t          dec;
    logic [N_LINES-1:0] wbits;
    logic [N_LINES-1:0] fld_q [N_FIELDS];
    logic [N_LINES-1:0] own_q, oe_q, dat_q, flt_q, msk_q;
    logic [N_LINES-1:0] lvl, chg_pulse, chg_q;
    logic               rd_clr;
    logic [N_LINES-1:0] rd_mux;
    logic [31:0]        rdata_q;

    assign dec   = decode_addr(reg_addr);
    assign wbits = reg_wdata[N_LINES-1:0];

    for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
        localparam logic [N_LINES-1:0] FMASK = (f == int'(FLD_OWN)) ? DEDICATED : '0;
        localparam logic [N_LINES-1:0] RVAL  = (f == int'(FLD_OWN)) ? '1 : '0;
        gpio_setclr_bank #(
            .N_LINES (N_LINES),
            .FIX_MASK(FMASK),
            .RST_VAL (RVAL)
        ) u_bank (
            .clk   (clk),
            .rst   (rst),
            .set_en(reg_wr && dec.is_set && (dec.fld == 3'(f))),
            .clr_en(reg_wr && dec.is_clr && (dec.fld == 3'(f))),
            .wbits (wbits),
            .q     (fld_q[f])
        );
    end

    assign own_q = fld_q[FLD_OWN];
    assign oe_q  = fld_q[FLD_OE];
    assign dat_q = fld_q[FLD_DAT];
    assign flt_q = fld_q[FLD_FLT];
    assign msk_q = fld_q[FLD_MSK];

    gpio_in_path #(.N_LINES(N_LINES)) u_in (
        .clk      (clk),
        .rst      (rst),
        .pad_in   (pad_in),
        .flt_en   (flt_q),
        .lvl      (lvl),
        .chg_pulse(chg_pulse)
    );

    assign rd_clr = reg_rd && (reg_addr == ADDR_CHG);

    gpio_chg_status #(.N_LINES(N_LINES)) u_chg (
        .clk      (clk),
        .rst      (rst),
        .chg_pulse(chg_pulse),
        .rd_clr   (rd_clr),
        .chg      (chg_q)
    );

    // pad drive: GPIO state where GPIO owns the line, peripheral elsewhere
    assign pad_out = (own_q & dat_q) | (~own_q & per_out);
    assign pad_oe  = (own_q & oe_q)  | (~own_q & per_oe);
    assign per_in  = ~own_q & lvl;
    assign irq     = |(chg_q & msk_q);

    always_comb begin
        rd_mux = '0;
        if (dec.is_stat)               rd_mux = fld_q[dec.fld];
        else if (reg_addr == ADDR_PIN) rd_mux = lvl;
        else if (reg_addr == ADDR_CHG) rd_mux = chg_q;
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (reg_rd) rdata_q <= 32'(rd_mux);
    end

    assign reg_rdata = rdata_q;
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
    parameter int N_LINES = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_rd,
    input logic [4:0]         reg_addr,
    input logic [31:0]        reg_rdata,
    input logic               irq,
    input logic [N_LINES-1:0] chg_q,
    input logic [N_LINES-1:0] msk_q,
    input logic [N_LINES-1:0] chg_pulse
);
    // R1: leaving reset, no interrupt and no change pending
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!irq && chg_q == '0));

    // R10: no mask bit set means no interrupt
    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (msk_q == '0) |-> !irq);

    // R8: change bits are sticky unless the status register is read
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd && reg_addr == 5'd16) |=> ((chg_q & $past(chg_q)) == $past(chg_q)));

    // R9: a read with no coincident change leaves nothing set
    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 5'd16 && chg_pulse == '0) |=> (chg_q == '0));

    // R12: read data holds between reads
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata));

    if (N_LINES < 32) begin : g_upper
        // R11: bits above the port never read as 1
        a_r11_upper_zero: assert property (@(posedge clk) disable iff (rst)
            reg_rdata[31:N_LINES] == '0);
    end
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.N_LINES(N_LINES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .irq      (irq),
    .chg_q    (chg_q),
    .msk_q    (msk_q),
    .chg_pulse(chg_pulse)
);

// File: tb/gpio_mux_port_tb.sv
module gpio_mux_port_tb;
    localparam int          N   = 12;
    localparam logic [11:0] MUX = 12'hF3C;
    localparam logic [11:0] DED = 12'h0C3;
    localparam logic [11:0] ALL = 12'hFFF;

    localparam logic [4:0] A_OWN_S = 0,  A_OWN_C = 1,  A_OWN_R = 2;
    localparam logic [4:0] A_OE_S  = 3,  A_OE_C  = 4,  A_OE_R  = 5;
    localparam logic [4:0] A_DAT_S = 6,  A_DAT_C = 7,  A_DAT_R = 8;
    localparam logic [4:0] A_FLT_S = 9,  A_FLT_C = 10, A_FLT_R = 11;
    localparam logic [4:0] A_MSK_S = 12, A_MSK_C = 13, A_MSK_R = 14;
    localparam logic [4:0] A_PIN = 15, A_CHG = 16;

    logic          clk = 0;
    logic          rst = 1;
    logic          reg_wr = 0, reg_rd = 0;
    logic [4:0]    reg_addr = 0;
    logic [31:0]   reg_wdata = 0;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  pad_in = 0, pad_out, pad_oe;
    logic [N-1:0]  per_out = 0, per_oe = 0, per_in;
    logic          irq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_mux_port #(.N_LINES(N), .MUX_MASK(MUX)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .per_out(per_out), .per_oe(per_oe), .per_in(per_in), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #4_000_000;
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [11:0] model, own_m, oe_m, dat_m, pat;
        logic [4:0]  sa [4];
        sa[0] = A_OE_S; sa[1] = A_DAT_S; sa[2] = A_FLT_S; sa[3] = A_MSK_S;

        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        rd(A_OWN_R, d); chk("R1 owner", d, 32'hFFF);
        rd(A_OE_R,  d); chk("R1 oe", d, 0);
        rd(A_DAT_R, d); chk("R1 data", d, 0);
        rd(A_FLT_R, d); chk("R1 filter", d, 0);
        rd(A_MSK_R, d); chk("R1 mask", d, 0);
        rd(A_CHG,   d); chk("R1 change", d, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2: walk every line through set then clear for four fields
        for (int f = 0; f < 4; f++) begin
            model = 0;
            for (int i = 0; i < N; i++) begin
                wr(sa[f], 32'(1) << i);
                model[i] = 1'b1;
                rd(sa[f] + 5'd2, d); chk("R2 set walk", d, 32'(model));
            end
            for (int i = 0; i < N; i += 2) begin
                wr(sa[f] + 5'd1, 32'(3) << i);
                model = model & ~(12'd3 << i);
                rd(sa[f] + 5'd2, d); chk("R2 clear walk", d, 32'(model));
            end
        end

        // R3: dedicated lines keep ownership
        wr(A_OWN_C, 32'hFFFF_FFFF);
        rd(A_OWN_R, d); chk("R3 clear all", d, 32'(DED));
        wr(A_OWN_S, 32'h0000_0030);
        rd(A_OWN_R, d); chk("R3 set two", d, 32'(DED | 12'h030));
        wr(A_OWN_C, 32'(DED));
        rd(A_OWN_R, d); chk("R3 clear dedicated", d, 32'(DED | 12'h030));

        // R11: upper bits ignored, unmapped reads zero
        wr(A_OE_S, 32'hFFFF_F000);
        rd(A_OE_R, d); chk("R11 upper write", d, 0);
        wr(A_OE_S, 32'hFFFF_FFFF);
        rd(A_OE_R, d); chk("R11 full write", d, 32'(ALL));
        rd(5'd20, d);  chk("R11 unmapped", d, 0);
        rd(5'd31, d);  chk("R11 unmapped high", d, 0);

        // R5: pad drive for several patterns under both ownership states
        for (int p = 0; p < 4; p++) begin
            pat = 12'h5A3 ^ (12'h3C7 * p[11:0]);
            own_m = (p[0]) ? ALL : DED | (pat & MUX);
            oe_m  = ~pat;
            dat_m = pat ^ 12'h0F0;
            wr(A_OWN_S, 32'(ALL)); wr(A_OWN_C, 32'(~own_m));
            wr(A_OE_S, 32'(ALL));  wr(A_OE_C, 32'(~oe_m));
            wr(A_DAT_S, 32'(ALL)); wr(A_DAT_C, 32'(~dat_m));
            per_out = pat + 12'h111;
            per_oe  = ~pat ^ 12'h00F;
            @(negedge clk);
            chk("R5 pad_out", 32'(pad_out), 32'((own_m & dat_m) | (~own_m & per_out)));
            chk("R5 pad_oe",  32'(pad_oe),  32'((own_m & oe_m) | (~own_m & per_oe)));
        end

        // R4, R6: peripheral input and pin level
        wr(A_FLT_C, 32'(ALL));
        wr(A_OWN_C, 32'(ALL));
        own_m = DED;
        for (int p = 0; p < 4; p++) begin
            pad_in = 12'hA5C ^ (12'h1E3 << p);
            settle();
            rd(A_PIN, d); chk("R6 pin level", d, 32'(pad_in));
            chk("R4 peripheral in", 32'(per_in), 32'(pad_in & ~own_m));
        end
        wr(A_OWN_S, 32'(ALL));
        chk("R4 gpio owned zero", 32'(per_in), 0);
        // R6: unfiltered latency, visible on the third clock
        rd(A_CHG, d);
        @(negedge clk);
        pad_in = ~pad_in;
        @(negedge clk); @(negedge clk);
        rd(A_PIN, d); chk("R6 latency", d, 32'(pad_in));

        // R8: each line toggled under mixed owner and direction
        wr(A_OWN_C, 32'h0000_0AAA);
        settle();
        rd(A_CHG, d);
        for (int i = 0; i < N; i++) begin
            pad_in[i] = ~pad_in[i];
            settle();
            rd(A_CHG, d); chk("R8 line change", d, 32'(1) << i);
        end
        rd(A_CHG, d); chk("R9 cleared", d, 0);

        // R10: interrupt and mask
        pad_in[3] = ~pad_in[3];
        settle();
        chk("R10 masked", {31'd0, irq}, 0);
        wr(A_MSK_S, 32'h0000_0004);
        chk("R10 other mask", {31'd0, irq}, 0);
        wr(A_MSK_S, 32'h0000_0008);
        chk("R10 unmasked", {31'd0, irq}, 1);
        rd(A_CHG, d);
        chk("R10 after read", {31'd0, irq}, 0);
        wr(A_MSK_C, 32'(ALL));

        // R7: glitch filter
        wr(A_FLT_S, 32'(ALL));
        settle();
        rd(A_CHG, d);
        pat = pad_in;
        @(negedge clk); pad_in[2] = ~pad_in[2];
        @(negedge clk); pad_in[2] = ~pad_in[2];
        settle();
        rd(A_CHG, d); chk("R7 short pulse rejected", d, 0);
        rd(A_PIN, d); chk("R7 level kept", d, 32'(pat));
        @(negedge clk); pad_in[2] = ~pad_in[2];
        repeat (3) @(negedge clk); pad_in[2] = ~pad_in[2];
        settle();
        rd(A_CHG, d); chk("R7 long pulse seen", d, 32'h4);
        wr(A_FLT_C, 32'(ALL));
        settle();
        rd(A_CHG, d);
        @(negedge clk); pad_in[2] = ~pad_in[2];
        @(negedge clk); pad_in[2] = ~pad_in[2];
        settle();
        rd(A_CHG, d); chk("R7 unfiltered pulse seen", d, 32'h4);

        // R9: change coincident with the clearing read
        @(negedge clk);
        pad_in[5] = ~pad_in[5];
        @(negedge clk); @(negedge clk);
        rd(A_CHG, d); chk("R9 read before set", d, 0);
        rd(A_CHG, d); chk("R9 kept set", d, 32'h20);
        rd(A_CHG, d); chk("R9 then clear", d, 0);

        // R12: data held after the read strobe drops
        rd(A_OWN_R, d);
        repeat (3) @(negedge clk);
        chk("R12 hold", reg_rdata, d);

        finish_run();
    end
endmodule